// File: doc/BRIEF.md
# Double-Buffered Nibble-Loaded Converter Code Register

This block models, as synchronous logic, the digital input path of a 12-bit voltage-output converter. A 12-bit data bus is split into three 4-bit nibbles. Each nibble has its own first-rank holding register with its own active-low enable. A 12-bit second-rank register holds the code that the converter actually uses. A host can assemble a new code one nibble at a time and then move it to the second rank in one step, so the converter output never passes through a half-written value. A single write with every enable low passes the bus value straight through both ranks.

All writes are qualified by an active-low write strobe. On a rising clock edge with the strobe low, every first-rank nibble whose enable is low takes its slice of the bus. If the load enable is also low, the second rank takes the first-rank value as it stands after that same edge's nibble updates. A format input inverts the code MSB before storage, so that two's-complement data is held internally as offset binary. The outputs are the stored code (read as unipolar straight binary or offset binary), a two's-complement view of that code, a midscale flag and a one-cycle update pulse.

Top module: `dbr_dac_code_reg`

## Requirements
- R1: While rst_ni is low, both ranks clear to 0x000 and upd_o is 0. Consequently code_o is 0x000, twos_o is 0x800 and mid_o is 0.
- R2: On an edge with wr_ni high, neither rank changes and upd_o is 0 on the next cycle, whatever the other inputs are.
- R3: With wr_ni low, nib_ni = 3'b011 (bit 2 low) and ld_ni high, only first-rank bits 11:8 load from data_i[11:8]. code_o is unchanged.
- R4: With wr_ni low, nib_ni = 3'b101 (bit 1 low) and ld_ni high, only first-rank bits 7:4 load from data_i[7:4].
- R5: With wr_ni low, nib_ni = 3'b110 (bit 0 low) and ld_ni high, only first-rank bits 3:0 load from data_i[3:0].
- R6: With wr_ni low, nib_ni = 3'b111 and ld_ni low, the second rank copies the whole first rank, and data_i has no effect.
- R7: The second rank, and therefore code_o, changes only on an edge where wr_ni and ld_ni are both low.
- R8: With wr_ni, ld_ni and all nib_ni bits low, code_o shows the (format-adjusted) bus value right after that one edge.
- R9: For any other combination of low enables with wr_ni low, the enabled nibbles load, and when ld_ni is low the second rank takes the first-rank value that results after those same-edge nibble loads.
- R10: When fmt_twos_i is 1 during a write, data_i[11] is inverted before it is stored. When fmt_twos_i is 0, the bus is stored as is.
- R11: twos_o equals code_o minus 0x800, modulo 4096. mid_o is 1 exactly when code_o is 0x800, the bipolar zero. Across the major carry 0x7FF to 0x800, twos_o goes from 0xFFF to 0x000.
- R12: upd_o is 1 for exactly the cycle after an edge on which the second-rank value changed, and 0 after any edge that leaves it unchanged, including a reload of the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 12 | Data bus |
| wr_ni | input | 1 | Write strobe, active low |
| nib_ni | input | 3 | First-rank nibble enables, active low; bit i covers data bits 4i+3..4i |
| ld_ni | input | 1 | Second-rank load enable, active low |
| fmt_twos_i | input | 1 | Incoming data is two's complement (MSB inverted on storage) |
| code_o | output | 12 | Second-rank code |
| twos_o | output | 12 | Two's-complement view of code_o |
| mid_o | output | 1 | code_o equals bipolar zero 0x800 |
| upd_o | output | 1 | One-cycle pulse when the second rank changed |

## Verification
A first-rank nibble loaded wrongly does not show at the ports until the next second-rank load, so the bench always follows partial loads with a load-only or mixed write and compares the whole code one cycle later. Errors in the second rank, the format inversion or the update pulse show on code_o, twos_o and upd_o in the cycle right after the faulty edge. The sweep covers all 32 control combinations, with several data patterns and both formats, against an arithmetic model of the two ranks.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  localparam int unsigned NIB_W   = 4;
  localparam int unsigned NUM_NIB = 3;
endpackage

// File: rtl/dbr_nibble_latch.sv
module dbr_nibble_latch #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] nxt_o
);
  // value after this edge, used by the second rank for same-edge transparency
  assign nxt_o = en_i ? d_i : q_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= nxt_o;
  end

  // R2 R3 R4 R5: a disabled nibble holds its value
  a_r2_nib_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_o));
  a_r3_nib_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> q_o == $past(d_i));
endmodule

// File: rtl/dbr_second_rank.sv
module dbr_second_rank #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         upd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o   <= '0;
      upd_o <= 1'b0;
    end else begin
      upd_o <= en_i && (d_i != q_o);
      if (en_i) q_o <= d_i;
    end
  end

  a_r12_upd_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(q_o) |-> upd_o);
  a_r12_upd_only_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> !$stable(q_o));
  a_r7_rank_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_o) && !upd_o);
endmodule

// File: rtl/dbr_code_view.sv
module dbr_code_view #(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] code_i,
  output logic [W-1:0] twos_o,
  output logic         mid_o
);
  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

  assign twos_o = {~code_i[W-1], code_i[W-2:0]};
  assign mid_o  = ~|twos_o;

  always_comb begin
    a_r11_view: assert (twos_o == W'(code_i - MID) && mid_o == (code_i == MID));
  end
endmodule

// File: rtl/dbr_dac_code_reg.sv
module dbr_dac_code_reg
  import dbr_pkg::*;
#(
  parameter int unsigned NW = NIB_W,
  parameter int unsigned NN = NUM_NIB
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NW*NN-1:0] data_i,
  input  logic             wr_ni,
  input  logic [NN-1:0]    nib_ni,
  input  logic             ld_ni,
  input  logic             fmt_twos_i,
  output logic [NW*NN-1:0] code_o,
  output logic [NW*NN-1:0] twos_o,
  output logic             mid_o,
  output logic             upd_o
);
  localparam int unsigned W = NW * NN;

  logic [W-1:0]  bus_fmt;
  logic [W-1:0]  rank1_q;
  logic [W-1:0]  rank1_nxt;
  logic [NN-1:0] nib_en;
  logic          ld_en;

  // two's complement input stored as offset binary
  assign bus_fmt = {data_i[W-1] ^ fmt_twos_i, data_i[W-2:0]};
  assign ld_en   = ~(wr_ni | ld_ni);

  for (genvar i = 0; i < NN; i++) begin : g_nib
    assign nib_en[i] = ~(wr_ni | nib_ni[i]);
    dbr_nibble_latch #(.W(NW)) u_nib (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (nib_en[i]),
      .d_i   (bus_fmt[i*NW +: NW]),
      .q_o   (rank1_q[i*NW +: NW]),
      .nxt_o (rank1_nxt[i*NW +: NW])
    );
  end

  dbr_second_rank #(.W(W)) u_rank2 (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (ld_en),
    .d_i   (rank1_nxt),
    .q_o   (code_o),
    .upd_o (upd_o)
  );

  dbr_code_view #(.W(W)) u_view (
    .code_i(code_o),
    .twos_o(twos_o),
    .mid_o (mid_o)
  );

  a_r2_strobe_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ni |=> $stable(code_o) && !upd_o);
  a_r7_needs_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ni || ld_ni) |=> $stable(code_o));
  a_r8_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ni && !ld_ni && nib_ni == '0) |=>
      code_o == $past({data_i[W-1] ^ fmt_twos_i, data_i[W-2:0]}));
  a_r6_load_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ni && !ld_ni && &nib_ni) |=> code_o == $past(rank1_q));
endmodule

// File: tb/dbr_dac_code_reg_test.sv
`timescale 1ns/1ps
module dbr_dac_code_reg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] data = '0;
  logic        wr_n = 1'b1;
  logic [2:0]  nib_n = 3'b111;
  logic        ld_n = 1'b1;
  logic        fmt = 1'b0;
  logic [11:0] code, twos;
  logic        mid, upd;

  int n_chk = 0;
  int n_fail = 0;
  logic [11:0] m_r1 = '0;
  logic [11:0] m_r2 = '0;
  logic        m_upd = 1'b0;

  always #10 clk = ~clk;

  dbr_dac_code_reg uut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .wr_ni(wr_n), .nib_ni(nib_n),
    .ld_ni(ld_n), .fmt_twos_i(fmt), .code_o(code), .twos_o(twos),
    .mid_o(mid), .upd_o(upd)
  );

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%03h expected 0x%03h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic w, input logic [2:0] n, input logic l);
    if (w) return "R2";
    if (!l && n == 3'b000) return "R8";
    if (!l && n == 3'b111) return "R6";
    if (l && n == 3'b011) return "R3";
    if (l && n == 3'b101) return "R4";
    if (l && n == 3'b110) return "R5";
    if (l && n == 3'b111) return "R7";
    return "R9";
  endfunction

  task automatic step(input logic w, input logic [2:0] n, input logic l,
                      input logic [11:0] d, input logic f, input string tag);
    logic [11:0] dd;
    logic [11:0] nx;
    @(negedge clk);
    wr_n = w; nib_n = n; ld_n = l; data = d; fmt = f;
    dd = f ? (d ^ 12'h800) : d;
    nx = m_r2;
    if (!w) begin
      for (int i = 0; i < 3; i++)
        if (!n[i]) m_r1[i*4 +: 4] = dd[i*4 +: 4];
      if (!l) nx = m_r1;
    end
    m_upd = (nx != m_r2);
    m_r2 = nx;
    @(posedge clk); #1;
    chk(tag, code, m_r2);
    chk("R12 upd", {11'd0, upd}, {11'd0, m_upd});
    chk("R11 twos", twos, m_r2 - 12'h800);
    chk("R11 mid", {11'd0, mid}, {11'd0, m_r2 == 12'h800});
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #25;
    chk("R1 code", code, 12'h000);
    chk("R1 upd", {11'd0, upd}, 12'h000);
    chk("R1 twos", twos, 12'h800);
    chk("R1 mid", {11'd0, mid}, 12'h000);
    @(negedge clk); rst_n = 1'b1;

    // build 0xABC nibble by nibble, then move with garbage on the bus
    step(0, 3'b011, 1, 12'hA55, 0, "R3");
    step(0, 3'b101, 1, 12'h5B5, 0, "R4");
    step(0, 3'b110, 1, 12'h55C, 0, "R5");
    step(1, 3'b000, 0, 12'hFFF, 0, "R2");
    step(0, 3'b111, 0, 12'h123, 0, "R6");
    chk("R6 value", code, 12'hABC);
    step(0, 3'b111, 0, 12'h321, 0, "R12 reload same");
    chk("R12 no pulse", {11'd0, upd}, 12'h000);
    // major carry through transparent writes
    step(0, 3'b000, 0, 12'h7FF, 0, "R8");
    chk("R11 carry low", twos, 12'hFFF);
    step(0, 3'b000, 0, 12'h800, 0, "R8");
    chk("R11 carry zero", twos, 12'h000);
    chk("R11 mid flag", {11'd0, mid}, 12'h001);
    // two's-complement format: 0x000 stored as bipolar zero
    step(0, 3'b000, 0, 12'h000, 1, "R10");
    chk("R10 msb inverted", code, 12'h800);
    step(0, 3'b000, 0, 12'hFFF, 1, "R10");
    chk("R10 minus one", code, 12'h7FF);
    // mixed: nibble A and load in one edge
    step(0, 3'b011, 0, 12'h3EE, 0, "R9");
    chk("R9 mixed", code, 12'h3FF);

    // sweep of every control combination
    for (int k = 0; k < 6; k++) begin
      for (int c = 0; c < 32; c++) begin
        logic [11:0] d;
        d = 12'((c * 12'h9D3) ^ (k * 12'h5A7) ^ (k << 9));
        step(c[4], c[3:1], c[0], d, k[0], tag_of(c[4], c[3:1], c[0]));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule